// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects interrupt requests from thirty-two peripheral sources and presents them to a processor core on two active-low request lines. Source 0 has its own fast line. Every other source shares the normal line. Each source has a pending bit and a mask bit. A source requests service only when both bits are set.

Software uses a small synchronous register bus. Reading the vector register returns the number of the lowest pending source and acknowledges that source in the same access. The number most recently returned stays readable in a status register. Write-only command registers do the following:
- set mask bits,
- clear mask bits,
- clear pending bits,
- signal end of interrupt.

Peripherals set pending bits through a request input that is sampled on every clock.

The bus side is handled by a two-state machine.
- BUS_IDLE moves to BUS_RESP when a read strobe arrives.
- BUS_RESP stays in BUS_RESP if another read strobe arrives.
- BUS_RESP returns to BUS_IDLE when there is no strobe.

While the machine is in BUS_RESP, `rd_valid` is high and `rdata` holds the answer to the previous read.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all pending bits and all mask bits are zero and both request lines are high. Reading the mask register (address 2) returns 0, and reading the status register (address 1) returns 0.
- R2: A high bit on `req_in` during a clock edge sets the matching pending bit.
- R3: `fiq_n` is low exactly when pending bit 0 and mask bit 0 are both set.
- R4: `irq_n` is low exactly when, for at least one of sources 31 down to 1, both the pending bit and the mask bit are set.
- R5: A read of the vector register (address 0) returns the index of the lowest-numbered pending bit and clears that bit. The mask plays no part in this scan. If no bit is pending, the read returns 0.
- R6: A read of the status register (address 1) returns the value that the most recent vector read produced.
- R7: A write to address 4 ORs the written data into the mask, and a write to address 5 clears the mask bits that are set in the data. A read of address 2 returns the current mask.
- R8: A write to address 6 clears the pending bits that are set in the written data.
- R9: A write to address 7 (end of interrupt) clears the pending bits that are set in the written data. The request lines reflect the change from the next cycle onward.
- R10: If a request and a clear (command write or vector acknowledge) hit the same pending bit in the same cycle, the bit stays set.
- R11: `rd_valid` is high in the cycle after each read strobe and low otherwise. Reads of unmapped addresses (for example address 3) return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 32 | Per-source request inputs, high sets pending |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_valid is high |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| fiq_n | output | 1 | Fast request line, active low, source 0 |
| irq_n | output | 1 | Normal request line, active low, sources 31..1 |

## Verification
A peripheral request and a software clear can land on the same pending bit in one clock. The clear may come from a clear-command write or from the acknowledge that a vector read performs. The bench provokes both cases by holding `req_in` high on a bit in exactly the cycle where it issues the clearing write or the vector read. It judges the result at the ports: the bit must still be pending, so the next vector read returns the same index again and the read after that returns 0. Around these cases the bench sweeps every source through request, enable, line check, vector acknowledge and status readback.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int ADDR_W = 4;

    // Register word addresses
    localparam logic [ADDR_W-1:0] A_VECTOR  = 4'd0;
    localparam logic [ADDR_W-1:0] A_STATUS  = 4'd1;
    localparam logic [ADDR_W-1:0] A_MASK    = 4'd2;
    localparam logic [ADDR_W-1:0] A_MASK_EN = 4'd4;
    localparam logic [ADDR_W-1:0] A_MASK_DS = 4'd5;
    localparam logic [ADDR_W-1:0] A_PEND_CL = 4'd6;
    localparam logic [ADDR_W-1:0] A_EOI     = 4'd7;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/irq_lowest_scan.sv
module irq_lowest_scan #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] vec,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    // Chain of "nothing below me" flags, built bit by bit
    logic [NUM_SRC:0]   none_below;
    logic [NUM_SRC-1:0] first_hot;

    assign none_below[0] = 1'b1;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
        assign first_hot[g]      = vec[g] & none_below[g];
        assign none_below[g + 1] = none_below[g] & ~vec[g];
    end

    assign found = ~none_below[NUM_SRC];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (first_hot[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_in,
    input  logic [NUM_SRC-1:0] set_mask,
    input  logic [NUM_SRC-1:0] clr_mask,
    input  logic [NUM_SRC-1:0] clr_pend,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] mask
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            mask <= '0;
        end else begin
            // Set wins over clear
            pend <= (pend & ~clr_pend) | req_in;
            mask <= (mask | set_mask) & ~clr_mask;
        end
    end

    // R2
    req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_in) |=> ((pend & $past(req_in)) == $past(req_in)));

    // R8
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_pend & ~req_in)) |=> ((pend & $past(clr_pend & ~req_in)) == '0));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_pend & req_in)) |=> ((pend & $past(clr_pend & req_in)) == $past(clr_pend & req_in)));

    // R7
    mask_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|set_mask) && !(|clr_mask)) |=> ((mask & $past(set_mask)) == $past(set_mask)));

    // R7
    mask_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_mask) |=> ((mask & $past(clr_mask)) == '0));

endmodule

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_vec_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] set_mask,
    output logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] clr_pend,
    output logic [DATA_W-1:0]  rdata,
    output logic               rd_valid
);
    bus_state_e state, state_nx;

    logic             scan_found;
    logic [IDX_W-1:0] scan_idx;
    logic [DATA_W-1:0] vec_value;
    logic [DATA_W-1:0] last_vec;
    logic [DATA_W-1:0] rdata_nx;
    logic              vec_rd;

    irq_lowest_scan #(.NUM_SRC(NUM_SRC)) u_scan (
        .vec   (pend),
        .found (scan_found),
        .idx   (scan_idx)
    );

    assign vec_rd    = rd_en && (addr == A_VECTOR);
    assign vec_value = scan_found ? DATA_W'(scan_idx) : '0;

    // Command decode
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        clr_pend = '0;
        if (wr_en) begin
            unique case (addr)
                A_MASK_EN: set_mask = wdata[NUM_SRC-1:0];
                A_MASK_DS: clr_mask = wdata[NUM_SRC-1:0];
                A_PEND_CL,
                A_EOI:     clr_pend = wdata[NUM_SRC-1:0];
                default: ;
            endcase
        end
        if (vec_rd && scan_found) begin
            clr_pend[scan_idx] = 1'b1;
        end
    end

    // Read mux
    always_comb begin
        unique case (addr)
            A_VECTOR: rdata_nx = vec_value;
            A_STATUS: rdata_nx = last_vec;
            A_MASK:   rdata_nx = DATA_W'(mask);
            default:  rdata_nx = '0;
        endcase
    end

    // Next-state logic
    always_comb begin
        unique case (state)
            BUS_IDLE: state_nx = rd_en ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_nx = rd_en ? BUS_RESP : BUS_IDLE;
            default:  state_nx = BUS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= state_nx;
    end

    // Output / data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            last_vec <= '0;
        end else begin
            if (rd_en)  rdata    <= rdata_nx;
            if (vec_rd) last_vec <= vec_value;
        end
    end

    assign rd_valid = (state == BUS_RESP);

    // R11
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R11
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R6
    status_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd |=> (last_vec == rdata));

    // R5
    ack_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && scan_found) |-> (pend[scan_idx] && $onehot0(pend & ((NUM_SRC'(1) << scan_idx) - NUM_SRC'(1)) & pend) == 1'b1 && (pend & ((NUM_SRC'(1) << scan_idx) - NUM_SRC'(1))) == '0));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_in,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               rd_valid,
    output logic               fiq_n,
    output logic               irq_n
);
    logic [NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0] mask_w;
    logic [NUM_SRC-1:0] set_mask_w;
    logic [NUM_SRC-1:0] clr_mask_w;
    logic [NUM_SRC-1:0] clr_pend_w;
    logic [NUM_SRC-1:0] active;

    irq_bus_fsm #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .pend     (pend_w),
        .mask     (mask_w),
        .set_mask (set_mask_w),
        .clr_mask (clr_mask_w),
        .clr_pend (clr_pend_w),
        .rdata    (rdata),
        .rd_valid (rd_valid)
    );

    irq_state_regs #(.NUM_SRC(NUM_SRC)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (req_in),
        .set_mask (set_mask_w),
        .clr_mask (clr_mask_w),
        .clr_pend (clr_pend_w),
        .pend     (pend_w),
        .mask     (mask_w)
    );

    assign active = pend_w & mask_w;
    assign fiq_n  = ~active[0];
    assign irq_n  = ~(|active[NUM_SRC-1:1]);

    // R3
    fiq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fiq_n |-> (mask_w[0] && pend_w[0]));

    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((|mask_w[NUM_SRC-1:1]) && (|pend_w[NUM_SRC-1:1])));

    // R1
    reset_lines_chk: assert property (@(posedge clk)
        !rst_n |=> (fiq_n && irq_n));

endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_in = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rd_valid;
    logic        fiq_n;
    logic        irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .rd_en(rd_en),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rd_valid(rd_valid), .fiq_n(fiq_n), .irq_n(irq_n)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
        chk("R11 rd_valid", {31'd0, rd_valid}, 32'd1);
    endtask

    task automatic pulse(input logic [31:0] r);
        req_in = r;
        @(negedge clk);
        req_in = '0;
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(negedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] pat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 fiq_n", {31'd0, fiq_n}, 32'd1);
        chk("R1 irq_n", {31'd0, irq_n}, 32'd1);
        chk("R11 idle rd_valid", {31'd0, rd_valid}, 32'd0);
        rd(4'd2, d); chk("R1 mask", d, 32'd0);
        rd(4'd1, d); chk("R1 status", d, 32'd0);
        @(negedge clk);
        chk("R11 rd_valid drops", {31'd0, rd_valid}, 32'd0);

        // Per-source sweep: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 32; i++) begin
            pulse(32'd1 << i);
            chk("R3 masked fiq", {31'd0, fiq_n}, 32'd1);
            chk("R4 masked irq", {31'd0, irq_n}, 32'd1);
            wr(4'd4, 32'd1 << i);
            chk("R3 fiq line", {31'd0, fiq_n}, (i == 0) ? 32'd0 : 32'd1);
            chk("R4 irq line", {31'd0, irq_n}, (i == 0) ? 32'd1 : 32'd0);
            rd(4'd2, d); chk("R7 mask read", d, 32'd1 << i);
            rd(4'd0, d); chk("R5 vector", d, 32'(i));
            chk("R5 ack lines", {30'd0, fiq_n, irq_n}, 32'd3);
            rd(4'd1, d); chk("R6 status", d, 32'(i));
            wr(4'd5, 32'd1 << i);
        end

        // R5 ordering over a pattern, mask ignored
        pat = 32'hA5A5_0F30;
        pulse(pat);
        for (int i = 0; i < 32; i++) begin
            if (pat[i]) begin
                rd(4'd0, d); chk("R5 ordered vector", d, 32'(i));
            end
        end
        rd(4'd0, d); chk("R5 empty vector", d, 32'd0);
        rd(4'd1, d); chk("R6 status after empty", d, 32'd0);

        // R7 enable/disable
        wr(4'd4, 32'h0000_F0F0);
        wr(4'd4, 32'h0000_0F00);
        rd(4'd2, d); chk("R7 enable or", d, 32'h0000_FFF0);
        wr(4'd5, 32'h0000_00FF);
        rd(4'd2, d); chk("R7 disable", d, 32'h0000_FF00);
        wr(4'd5, 32'hFFFF_FFFF);

        // R8 clear command
        pulse((32'd1 << 3) | (32'd1 << 9));
        wr(4'd6, 32'd1 << 3);
        rd(4'd0, d); chk("R8 cleared bit skipped", d, 32'd9);
        rd(4'd0, d); chk("R8 empty", d, 32'd0);

        // R9 end of interrupt
        wr(4'd4, 32'd1 << 5);
        pulse(32'd1 << 5);
        chk("R9 irq asserted", {31'd0, irq_n}, 32'd0);
        wr(4'd7, 32'd1 << 5);
        chk("R9 irq released", {31'd0, irq_n}, 32'd1);
        rd(4'd0, d); chk("R9 pending gone", d, 32'd0);
        wr(4'd5, 32'hFFFF_FFFF);

        // R10 request vs clear command, same cycle
        pulse(32'd1 << 7);
        req_in = 32'd1 << 7;
        wr(4'd6, 32'd1 << 7);
        req_in = '0;
        rd(4'd0, d); chk("R10 set beats clear", d, 32'd7);
        rd(4'd0, d); chk("R10 then empty", d, 32'd0);

        // R10 request vs vector acknowledge, same cycle
        pulse(32'd1 << 2);
        req_in = 32'd1 << 2;
        rd(4'd0, d);
        req_in = '0;
        chk("R10 ack vector", d, 32'd2);
        rd(4'd0, d); chk("R10 set beats ack", d, 32'd2);
        rd(4'd0, d); chk("R10 ack then empty", d, 32'd0);

        // R11 unmapped read
        wr(4'd4, 32'h1234_5678);
        rd(4'd3, d); chk("R11 unmapped", d, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule